// File: doc/BRIEF.md
# Invariance Checker Response Capture and Serial Readout

This block gathers the one-bit verdicts of six on-chip invariance checkers over a fixed test run and turns them into a time-resolved diagnostic bit pattern. Each verdict is 0 for pass and 1 for fail. Five checkers watch a quantity against a tolerance window and report two flags, one for crossing the upper limit and one for crossing the lower limit. The sixth checker compares signs and has no window, so it reports a single flag. For every checker and every cycle of the run, the block stores whether that checker failed in that cycle.

When the run is over, the stored pattern leaves the block as a one-bit stream with a valid/ready handshake, so a two-pin test access path can carry it off-chip. A mode input chooses between merged reporting and split reporting. In merged reporting a windowed checker gives one stream, the OR of its two flags. In split reporting it gives two separate streams, so a fault that breaks the upper limit can be told apart from one that breaks the lower limit. A done flag marks the end of the readout.

Back-pressure rule: while `out_valid` is high and `out_ready` is low, `out_data` and `out_valid` hold their values. A bit is consumed only on a clock edge where both are high. There is no limit on how long the consumer may stall.

Top module: `chk_pattern_capture`

## Requirements
- R1: After reset, `out_valid` is 0 and `done` is 0.
- R2: A `start` sampled high while the block is idle, or after a finished run, begins a capture of 32 cycles. Bit i of each stream is the flag value sampled at the i-th rising edge after the edge that accepted `start` (i = 0..31). Accepting a start clears `done` at that same edge.
- R3: In merged mode (`split_mode` = 0), each windowed checker k gives one stream equal to `win_hi[k] | win_lo[k]`. The readout is then 6 × 32 = 192 bits.
- R4: In split mode (`split_mode` = 1), each windowed checker gives its upper stream (`win_hi[k]`) followed by its lower stream (`win_lo[k]`). The sign checker keeps a single stream, so the readout is 5 × 64 + 32 = 352 bits.
- R5: Streams are sent in order: checker 0 first, then ascending checker index, with the sign checker (`sign_fail`) last. Within a stream the most significant bit comes first, which is bit 31, the latest sample; bit 0 comes last.
- R6: `out_valid` rises in the cycle after the edge that captures bit 31. Each edge with `out_valid` and `out_ready` both high moves exactly one bit.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` stays stable.
- R8: After the final bit is handed over, `out_valid` falls and `done` rises at the same edge. `done` stays high until the next accepted start, and `done` and `out_valid` are never high together.
- R9: A `start` that arrives during capture or readout is ignored. This includes a start in the cycle of the final handshake: the run's length and content do not change, and no new run begins.
- R10: `split_mode` is sampled together with the accepted `start`. Changes to it during the run have no effect on that run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Run request strobe |
| split_mode | input | 1 | 0 = merged window reporting, 1 = split window reporting |
| win_hi | input | 5 | Upper-limit violation flags of the windowed checkers (1 = fail) |
| win_lo | input | 5 | Lower-limit violation flags of the windowed checkers (1 = fail) |
| sign_fail | input | 1 | Verdict of the windowless sign checker (1 = fail) |
| out_ready | input | 1 | Consumer ready for the serial bit |
| out_valid | output | 1 | Serial bit is valid |
| out_data | output | 1 | Serial pattern bit |
| done | output | 1 | Readout finished |

## Verification
Two events can land on the same clock edge: the final handshake of a readout and a new start strobe. The bench raises `start` in exactly the cycle where the last bit is accepted. It then checks that `done` rises and stays high, that `out_valid` stays low for many cycles, and that no second capture begins. A second coincidence is a consumer stall on the last bit of a stream, which is where the stream index advances. The ready patterns that alternate, and those that drop one cycle in three, place stalls on stream boundaries. Each of those runs is judged by comparing the full received sequence against the pattern the bench computes itself.

// File: rtl/pc_pkg.sv
package pc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CAP   = 2'd1,
    ST_SHIFT = 2'd2,
    ST_DONE  = 2'd3
  } pc_state_t;

  function automatic int lane_total(input int n_win);
    return 2 * n_win + 1;
  endfunction
endpackage

// File: rtl/pc_lane.sv
module pc_lane #(
  parameter int LEN = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           shift_en,
  input  logic           bit_in,
  output logic [LEN-1:0] word
);
  // newest sample enters at the top; after LEN shifts bit i holds sample i
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word <= '0;
    end else if (shift_en) begin
      word <= {bit_in, word[LEN-1:1]};
    end
  end
endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
  import pc_pkg::*;
#(
  parameter int RUN_LEN = 32,
  parameter int N_WIN   = 5
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             start,
  input  logic                             split_in,
  input  logic                             out_ready,
  output logic                             cap_en,
  output logic                             out_valid,
  output logic                             done,
  output logic                             split_q,
  output logic [$clog2(2*N_WIN+1)-1:0]     slot,
  output logic [$clog2(RUN_LEN)-1:0]       bit_idx
);
  localparam int SLOT_W = $clog2(2 * N_WIN + 1);
  localparam int BIT_W  = $clog2(RUN_LEN);

  pc_state_t          state;
  logic [BIT_W-1:0]   cnt;
  logic [SLOT_W-1:0]  last_slot;

  assign last_slot = split_q ? SLOT_W'(2 * N_WIN) : SLOT_W'(N_WIN);
  assign cap_en    = (state == ST_CAP);
  assign out_valid = (state == ST_SHIFT);
  assign done      = (state == ST_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      slot    <= '0;
      bit_idx <= '0;
      split_q <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE, ST_DONE: begin
          if (start) begin
            state   <= ST_CAP;
            cnt     <= '0;
            split_q <= split_in;
          end
        end
        ST_CAP: begin
          if (cnt == BIT_W'(RUN_LEN - 1)) begin
            state   <= ST_SHIFT;
            slot    <= '0;
            bit_idx <= BIT_W'(RUN_LEN - 1);
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_SHIFT: begin
          if (out_ready) begin
            if (bit_idx == '0) begin
              if (slot == last_slot) begin
                state <= ST_DONE;
              end else begin
                slot    <= slot + 1'b1;
                bit_idx <= BIT_W'(RUN_LEN - 1);
              end
            end else begin
              bit_idx <= bit_idx - 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pc_serializer.sv
module pc_serializer #(
  parameter int RUN_LEN = 32,
  parameter int N_WIN   = 5
) (
  input  logic [RUN_LEN-1:0]               lanes [2*N_WIN+1],
  input  logic                             split_q,
  input  logic [$clog2(2*N_WIN+1)-1:0]     slot,
  input  logic [$clog2(RUN_LEN)-1:0]       bit_idx,
  output logic                             data
);
  localparam int N_LANES = 2 * N_WIN + 1;
  localparam int LANE_W  = $clog2(N_LANES);

  logic [LANE_W-1:0] lane;

  // lanes: [0..N_WIN-1] upper/merged, [N_WIN..2N_WIN-1] lower, [2N_WIN] sign
  always_comb begin
    if (!split_q) begin
      lane = (slot == LANE_W'(N_WIN)) ? LANE_W'(2 * N_WIN) : slot;
    end else if (slot == LANE_W'(2 * N_WIN)) begin
      lane = LANE_W'(2 * N_WIN);
    end else begin
      lane = (slot >> 1) + (slot[0] ? LANE_W'(N_WIN) : LANE_W'(0));
    end
  end

  always_comb begin
    data = 1'b0;
    for (int i = 0; i < N_LANES; i++) begin
      if (lane == LANE_W'(i)) data = lanes[i][bit_idx];
    end
  end
endmodule

// File: rtl/chk_pattern_capture.sv
module chk_pattern_capture
  import pc_pkg::*;
#(
  parameter int N_WIN   = 5,
  parameter int RUN_LEN = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             split_mode,
  input  logic [N_WIN-1:0] win_hi,
  input  logic [N_WIN-1:0] win_lo,
  input  logic             sign_fail,
  input  logic             out_ready,
  output logic             out_valid,
  output logic             out_data,
  output logic             done
);
  localparam int N_LANES = lane_total(N_WIN);
  localparam int LANE_W  = $clog2(N_LANES);
  localparam int BIT_W   = $clog2(RUN_LEN);

  logic               cap_en;
  logic               split_q;
  logic [LANE_W-1:0]  slot;
  logic [BIT_W-1:0]   bit_idx;
  logic [RUN_LEN-1:0] lanes [N_LANES];

  pc_sequencer #(.RUN_LEN(RUN_LEN), .N_WIN(N_WIN)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .split_in  (split_mode),
    .out_ready (out_ready),
    .cap_en    (cap_en),
    .out_valid (out_valid),
    .done      (done),
    .split_q   (split_q),
    .slot      (slot),
    .bit_idx   (bit_idx)
  );

  for (genvar k = 0; k < N_WIN; k++) begin : g_win
    // merged mode folds both flags into the upper lane at capture time
    pc_lane #(.LEN(RUN_LEN)) u_hi (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift_en (cap_en),
      .bit_in   (split_q ? win_hi[k] : (win_hi[k] | win_lo[k])),
      .word     (lanes[k])
    );
    pc_lane #(.LEN(RUN_LEN)) u_lo (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift_en (cap_en),
      .bit_in   (win_lo[k]),
      .word     (lanes[N_WIN+k])
    );
  end

  pc_lane #(.LEN(RUN_LEN)) u_sign (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (cap_en),
    .bit_in   (sign_fail),
    .word     (lanes[2*N_WIN])
  );

  pc_serializer #(.RUN_LEN(RUN_LEN), .N_WIN(N_WIN)) u_ser (
    .lanes   (lanes),
    .split_q (split_q),
    .slot    (slot),
    .bit_idx (bit_idx),
    .data    (out_data)
  );
endmodule

// File: rtl/pc_capture_props.sv
module pc_capture_props (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic out_valid,
  input logic out_ready,
  input logic out_data,
  input logic done
);
  p_valid_done_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_valid && done));

  p_stall_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  p_valid_drop_handshake_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_valid) |-> $past(out_ready));

  p_done_after_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(out_valid && out_ready));

  p_done_clear_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(done) |-> $past(start));

  p_no_restart_in_shift_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> !done);
endmodule

bind chk_pattern_capture pc_capture_props u_props (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .done      (done)
);

// File: tb/tb_chk_pattern_capture.sv
`timescale 1ns/1ps
module tb_chk_pattern_capture;
  localparam int NW   = 5;
  localparam int RL   = 32;
  localparam int MAXB = (2 * NW + 1) * RL;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic split_mode = 1'b0;
  logic [NW-1:0] win_hi = '0;
  logic [NW-1:0] win_lo = '0;
  logic sign_fail = 1'b0;
  logic out_ready = 1'b0;
  logic out_valid, out_data, done;

  int checks = 0;
  int failures = 0;

  logic [NW-1:0] hs [RL];
  logic [NW-1:0] ls [RL];
  logic          ss [RL];
  logic          exp_b [MAXB];
  logic          got_b [MAXB];
  int            n_exp;
  int            n_got;
  bit            stall_bad;

  always #5 clk = ~clk;

  chk_pattern_capture #(.N_WIN(NW), .RUN_LEN(RL)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .split_mode(split_mode),
    .win_hi(win_hi), .win_lo(win_lo), .sign_fail(sign_fail),
    .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data), .done(done)
  );

  // {split, kind[1:0], seed[15:0], ready_mode[1:0]}
  localparam logic [20:0] VEC [6] = '{
    {1'b0, 2'd0, 16'h1234, 2'd0},
    {1'b1, 2'd0, 16'hBEEF, 2'd0},
    {1'b0, 2'd0, 16'h0F0F, 2'd1},
    {1'b1, 2'd0, 16'h7A51, 2'd2},
    {1'b0, 2'd2, 16'h0000, 2'd0},
    {1'b1, 2'd2, 16'h0000, 2'd1}
  };

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic logic [10:0] gen(input int kind, input int seed, input int c);
    logic [31:0] h;
    h = (32'(seed) * 32'h9E3779B1) ^ (32'(c + 1) * 32'h85EBCA6B);
    h = h ^ (h >> 15);
    h = h * 32'h2C1B3C6D;
    h = h ^ (h >> 13);
    case (kind)
      1: return {1'b1, 5'b00000, 5'b11111};
      2: return {1'b0, 5'b11111, 5'b00000};
      3: return 11'd0;
      default: return h[20:10];
    endcase
  endfunction

  function automatic bit ready_at(input int rmode, input int cyc);
    case (rmode)
      1: return cyc[0];
      2: return (cyc % 3) != 0;
      default: return 1'b1;
    endcase
  endfunction

  // inj: 0 none, 1 start in capture, 2 start in shift, 3 start on final handshake
  task automatic run(input bit split, input int kind, input int seed, input int rmode,
                     input bit flip, input int inj, input string tag);
    bit v_early;
    int cyc;
    @(negedge clk);
    start = 1'b1; split_mode = split;
    @(negedge clk);
    start = 1'b0;
    check(done == 1'b0, "R2 done cleared by start", done, 0);
    if (flip) split_mode = ~split;
    for (int c = 0; c < RL; c++) begin
      logic [10:0] g;
      g = gen(kind, seed, c);
      win_hi = g[4:0]; win_lo = g[9:5]; sign_fail = g[10];
      hs[c] = g[4:0]; ls[c] = g[9:5]; ss[c] = g[10];
      start = (inj == 1 && c == 10);
      if (c == RL - 1) v_early = out_valid;
      @(negedge clk);
    end
    start = 1'b0;
    check(!v_early && out_valid, {"R6 valid timing ", tag}, out_valid, 1);
    // expected stream, built from the requirement text
    n_exp = 0;
    for (int k = 0; k <= NW; k++) begin
      for (int part = 0; part < (split && k < NW ? 2 : 1); part++) begin
        for (int b = RL - 1; b >= 0; b--) begin
          logic v;
          if (k == NW) v = ss[b];
          else if (!split) v = hs[b][k] | ls[b][k];
          else v = (part == 0) ? hs[b][k] : ls[b][k];
          exp_b[n_exp] = v;
          n_exp++;
        end
      end
    end
    n_got = 0; cyc = 0; stall_bad = 0;
    begin
      bit pstall;
      logic pdata;
      pstall = 0; pdata = 0;
      while (!done && cyc < 4000) begin
        out_ready = ready_at(rmode, cyc);
        start = (inj == 2 && n_got == 5) ||
                (inj == 3 && n_got == n_exp - 1 && out_ready);
        #1;
        if (pstall && (out_valid !== 1'b1 || out_data !== pdata)) stall_bad = 1;
        if (out_valid && out_ready) begin
          if (n_got < MAXB) got_b[n_got] = out_data;
          n_got++;
        end
        pstall = out_valid && !out_ready;
        pdata = out_data;
        @(negedge clk);
        cyc++;
      end
      start = 1'b0;
      out_ready = 1'b0;
    end
    check(n_got == n_exp, {split ? "R4 length " : "R3 length ", tag}, n_got, n_exp);
    begin
      int bad;
      bad = -1;
      for (int i = 0; i < n_exp && i < n_got; i++)
        if (bad < 0 && got_b[i] !== exp_b[i]) bad = i;
      check(bad < 0, {"R5 content ", tag}, bad, -1);
    end
    check(!stall_bad, {"R7 hold under stall ", tag}, stall_bad, 0);
    check(done && !out_valid, {"R8 done after last bit ", tag}, done, 1);
  endtask

  initial begin
    #1_500_000;
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R1 reset valid", out_valid, 0);
    check(done == 1'b0, "R1 reset done", done, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 6; i++) begin
      run(VEC[i][20], int'(VEC[i][19:18]), int'(VEC[i][17:2]), int'(VEC[i][1:0]),
          1'b0, 0, $sformatf("vec%0d", i));
    end

    // R10: mode toggled after acceptance has no effect
    run(1'b1, 0, 16'h3C3C, 0, 1'b1, 0, "R10 split flipped");
    run(1'b0, 1, 0, 0, 1'b1, 0, "R10 merged flipped");
    // R9: starts during capture and readout are ignored
    run(1'b0, 0, 16'h5555, 0, 1'b0, 1, "R9 start in capture");
    run(1'b1, 0, 16'h6666, 2, 1'b0, 2, "R9 start in shift");
    run(1'b0, 3, 0, 1, 1'b0, 3, "R9 start on last handshake");
    begin
      bit stayed;
      stayed = 1;
      for (int c = 0; c < 40; c++) begin
        #1;
        if (!done || out_valid) stayed = 0;
        @(negedge clk);
      end
      check(stayed, "R9 no restart after coincident start", stayed, 1);
    end
    // R8: done holds while idle
    check(done == 1'b1, "R8 done held", done, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule